// File: doc/BRIEF.md
# Flash write-buffer program sequencer

This block models the device side of buffered programming in a NOR-style flash. A host drives single-cycle write strobes carrying an address and a data word, and single-cycle read strobes whose result appears on the read data port in the same cycle. Two unlock writes start the sequence. A buffer-load command at an address inside the target sector follows. Then comes a word count written as (words - 1), then exactly that many address/data loads into one 16-word aligned page of the same sector, and finally a confirm command at the sector address. The block then spends a parameterized number of cycles programming. At the end it merges the buffered words into its internal array. Programming can only clear bits.

Every protocol violation during loading or confirmation puts the block in an abort state. That state shows a fixed status pattern on reads, and only the full three-write abort-reset sequence clears it. While programming runs, reads return polling status instead of array data. A timeout input turns a running program into a fault state. In the fault state DQ5 is set, and a reset command clears it. Unlock writes are AA at 0x555 and 55 at 0x2AA. The buffer-load command is 25, confirm is 29 and reset is F0. Commands are decoded on data bits [7:0].

Top module: `wbuf_prog_seq`

## Requirements
- R1: After reset the whole array reads as 0xFFFF, and reads outside any status state return the array word at the read address.
- R2: A complete sequence (unlock, 25 at SA, count, N loads, 29 at SA) writes every loaded word after PROG_CYCLES cycles. The stored value is old AND new, and words of the page that were not loaded keep their value.
- R3: When one buffer address is loaded several times, the data of the last load is the data programmed.
- R4: A count word above 15 (data greater than PAGE_WORDS-1) aborts the operation.
- R5: A count or load write whose address lies outside the sector of the buffer-load command aborts. The sector is address bits [AW-1:SECT_AW].
- R6: A load whose page (address bits [AW-1:4]) differs from the page of the first load aborts.
- R7: After the last load, any write other than 29 at an address inside the sector aborts.
- R8: In the abort state reads return bit1=1 and bit5=0. Bit7 is the complement of bit7 of the last accepted load data, or 1 when no load was accepted. Bit6 flips on every read, the other bits are 0, and the array is not written.
- R9: While aborted, all writes are ignored except the sequence AA at 0x555, 55 at 0x2AA, F0 at any address. That sequence returns the block to read mode. A new buffer-load attempt or a lone F0 leaves it aborted.
- R10: While programming, reads return bit7 equal to the complement of bit7 of the last loaded data, with bit6 flipping on each read and bit5=0, bit1=0. Writes during programming have no effect.
- R11: A timeout pulse during programming sets bit5=1 in status reads and cancels the array update. The block holds this state until an F0 write, after which it is in read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_re | input | 1 | Read strobe, one read per cycle it is high |
| bus_addr | input | AW (11) | Word address of the current cycle |
| bus_wdata | input | DW (16) | Write data |
| timeout_in | input | 1 | Programming timeout indication |
| bus_rdata | output | DW (16) | Array word or status word, combinational on address and state |

## Verification
The programming function is driven with page loads that use scattered offsets, with a second program over already-cleared bits, and with a repeated load to one offset. These patterns separate a correct AND merge and last-write-wins from a plain overwrite or a first-write-wins buffer. Each abort cause is triggered on its own: an oversized count, a foreign sector, a foreign page and a wrong confirm. Last-load data is chosen with bit7 both set and clear, so the DQ7 complement rule is visible. The reset-sequence tests and the timeout test show whether the hold states really ignore partial or unrelated writes.

// File: rtl/wbp_pkg.sv
package wbp_pkg;

    typedef enum logic [3:0] {
        S_READ,
        S_UNL1,
        S_UNL2,
        S_COUNT,
        S_LOAD,
        S_CONFIRM,
        S_PROG,
        S_ABORT,
        S_AB_UNL1,
        S_AB_UNL2,
        S_FAULT
    } wbp_state_e;

    localparam logic [7:0]  CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0]  CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0]  CMD_BUF_LOAD = 8'h25;
    localparam logic [7:0]  CMD_CONFIRM  = 8'h29;
    localparam logic [7:0]  CMD_RESET    = 8'hF0;
    localparam logic [10:0] UNL_ADDR_A   = 11'h555;
    localparam logic [10:0] UNL_ADDR_B   = 11'h2AA;

endpackage

// File: rtl/wbp_timer.sv
module wbp_timer #(
    parameter int CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int W = $clog2(CYCLES + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run ? cnt_q + W'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && (cnt_q == W'(CYCLES - 1));
endmodule

// File: rtl/wbp_buffer.sv
module wbp_buffer #(
    parameter int DW      = 16,
    parameter int PAGE_AW = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic                              wr,
    input  logic [PAGE_AW-1:0]                widx,
    input  logic [DW-1:0]                     wdata,
    output logic [(1<<PAGE_AW)-1:0][DW-1:0]   data,
    output logic [(1<<PAGE_AW)-1:0]           valid
);
    localparam int PAGE_WORDS = 1 << PAGE_AW;

    logic [PAGE_WORDS-1:0][DW-1:0] data_d, data_q;
    logic [PAGE_WORDS-1:0]         valid_d, valid_q;

    always_comb begin
        data_d  = data_q;
        valid_d = valid_q;
        if (clr) begin
            valid_d = '0;
        end else if (wr) begin
            data_d[widx]  = wdata;
            valid_d[widx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= '0;
        end else begin
            data_q  <= data_d;
            valid_q <= valid_d;
        end
    end

    assign data  = data_q;
    assign valid = valid_q;
endmodule

// File: rtl/wbp_array.sv
module wbp_array #(
    parameter int AW      = 11,
    parameter int DW      = 16,
    parameter int PAGE_AW = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [AW-1:0]                     raddr,
    output logic [DW-1:0]                     rdata,
    input  logic                              commit,
    input  logic [AW-PAGE_AW-1:0]             page_idx,
    input  logic [(1<<PAGE_AW)-1:0][DW-1:0]   pdata,
    input  logic [(1<<PAGE_AW)-1:0]           pvalid
);
    localparam int DEPTH      = 1 << AW;
    localparam int PAGE_WORDS = 1 << PAGE_AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] widx [PAGE_WORDS];

    for (genvar g = 0; g < PAGE_WORDS; g++) begin : g_widx
        assign widx[g] = {page_idx, PAGE_AW'(g)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (commit) begin
            for (int i = 0; i < PAGE_WORDS; i++) begin
                if (pvalid[i]) mem_q[widx[i]] <= mem_q[widx[i]] & pdata[i];
            end
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/wbuf_prog_seq.sv
module wbuf_prog_seq #(
    parameter int AW          = 11,
    parameter int DW          = 16,
    parameter int PAGE_AW     = 4,
    parameter int SECT_AW     = 8,
    parameter int PROG_CYCLES = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          timeout_in,
    output logic [DW-1:0] bus_rdata
);
    import wbp_pkg::*;

    localparam int PAGE_WORDS = 1 << PAGE_AW;
    localparam int SECT_W     = AW - SECT_AW;
    localparam int PAGE_W     = AW - PAGE_AW;
    localparam int CNT_W      = PAGE_AW + 1;

    typedef struct packed {
        wbp_state_e        state;
        logic [SECT_W-1:0] sector;
        logic [PAGE_W-1:0] page;
        logic              page_set;
        logic [CNT_W-1:0]  remain;
        logic              dq7_src;
        logic              toggle;
    } ctl_t;

    ctl_t d, q;

    logic buf_clr, buf_wr, commit, prog_done;
    logic unl_a, unl_b, in_sector, status_mode, abort_mode;
    logic [PAGE_WORDS-1:0][DW-1:0] buf_data;
    logic [PAGE_WORDS-1:0]         buf_valid;
    logic [DW-1:0]                 arr_rdata;
    wbp_state_e                    cur_state;

    assign cur_state = q.state;

    assign unl_a = bus_we && (bus_addr[10:0] == UNL_ADDR_A) && (bus_wdata[7:0] == CMD_UNLOCK_A);
    assign unl_b = bus_we && (bus_addr[10:0] == UNL_ADDR_B) && (bus_wdata[7:0] == CMD_UNLOCK_B);
    assign in_sector = (bus_addr[AW-1:SECT_AW] == q.sector);

    assign abort_mode  = (q.state == S_ABORT) || (q.state == S_AB_UNL1) || (q.state == S_AB_UNL2);
    assign status_mode = abort_mode || (q.state == S_PROG) || (q.state == S_FAULT);

    always_comb begin
        d       = q;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;
        commit  = 1'b0;

        if (bus_re && status_mode) d.toggle = ~q.toggle;

        case (q.state)
            S_READ: begin
                if (unl_a) d.state = S_UNL1;
            end
            S_UNL1: begin
                if (bus_we) d.state = unl_b ? S_UNL2 : S_READ;
            end
            S_UNL2: begin
                if (bus_we) begin
                    if (bus_wdata[7:0] == CMD_BUF_LOAD) begin
                        d.state    = S_COUNT;
                        d.sector   = bus_addr[AW-1:SECT_AW];
                        d.page_set = 1'b0;
                        d.dq7_src  = 1'b0;
                        buf_clr    = 1'b1;
                    end else begin
                        d.state = S_READ;
                    end
                end
            end
            S_COUNT: begin
                if (bus_we) begin
                    if (!in_sector || (bus_wdata > DW'(PAGE_WORDS - 1))) begin
                        d.state = S_ABORT;
                    end else begin
                        d.remain = CNT_W'(bus_wdata[PAGE_AW-1:0]) + CNT_W'(1);
                        d.state  = S_LOAD;
                    end
                end
            end
            S_LOAD: begin
                if (bus_we) begin
                    if (!in_sector || (q.page_set && (bus_addr[AW-1:PAGE_AW] != q.page))) begin
                        d.state = S_ABORT;
                    end else begin
                        buf_wr     = 1'b1;
                        d.page     = bus_addr[AW-1:PAGE_AW];
                        d.page_set = 1'b1;
                        d.dq7_src  = bus_wdata[7];
                        d.remain   = q.remain - CNT_W'(1);
                        if (q.remain == CNT_W'(1)) d.state = S_CONFIRM;
                    end
                end
            end
            S_CONFIRM: begin
                if (bus_we) begin
                    d.state = (in_sector && (bus_wdata[7:0] == CMD_CONFIRM)) ? S_PROG : S_ABORT;
                end
            end
            S_PROG: begin
                if (timeout_in) begin
                    d.state = S_FAULT;
                end else if (prog_done) begin
                    commit  = 1'b1;
                    d.state = S_READ;
                end
            end
            S_ABORT: begin
                if (unl_a) d.state = S_AB_UNL1;
            end
            S_AB_UNL1: begin
                if (bus_we) d.state = unl_b ? S_AB_UNL2 : S_ABORT;
            end
            S_AB_UNL2: begin
                if (bus_we) d.state = (bus_wdata[7:0] == CMD_RESET) ? S_READ : S_ABORT;
            end
            S_FAULT: begin
                if (bus_we && (bus_wdata[7:0] == CMD_RESET)) d.state = S_READ;
            end
            default: d.state = S_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: S_READ, sector: '0, page: '0, page_set: 1'b0,
                   remain: '0, dq7_src: 1'b0, toggle: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (status_mode) begin
            bus_rdata    = '0;
            bus_rdata[7] = ~q.dq7_src;
            bus_rdata[6] = q.toggle;
            bus_rdata[5] = (q.state == S_FAULT);
            bus_rdata[1] = abort_mode;
        end else begin
            bus_rdata = arr_rdata;
        end
    end

    wbp_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.state == S_PROG),
        .done  (prog_done)
    );

    wbp_buffer #(.DW(DW), .PAGE_AW(PAGE_AW)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr),
        .wr    (buf_wr),
        .widx  (bus_addr[PAGE_AW-1:0]),
        .wdata (bus_wdata),
        .data  (buf_data),
        .valid (buf_valid)
    );

    wbp_array #(.AW(AW), .DW(DW), .PAGE_AW(PAGE_AW)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .raddr    (bus_addr),
        .rdata    (arr_rdata),
        .commit   (commit),
        .page_idx (q.page),
        .pdata    (buf_data),
        .pvalid   (buf_valid)
    );
endmodule

// File: rtl/wbp_checker.sv
module wbp_checker #(
    parameter int AW      = 11,
    parameter int DW      = 16,
    parameter int PAGE_AW = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_we,
    input logic                  bus_re,
    input logic [AW-1:0]         bus_addr,
    input logic [DW-1:0]         bus_wdata,
    input logic [DW-1:0]         bus_rdata,
    input wbp_pkg::wbp_state_e   cur_state,
    input logic [AW-PAGE_AW-1:0] page,
    input logic                  page_set,
    input logic                  commit
);
    import wbp_pkg::*;

    // R4
    count_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == S_COUNT && bus_we && bus_wdata > DW'((1 << PAGE_AW) - 1)) |=> cur_state == S_ABORT);

    // R6
    page_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == S_LOAD && bus_we && page_set && bus_addr[AW-1:PAGE_AW] != page) |=> cur_state == S_ABORT);

    // R9
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_state == S_ABORT |=> (cur_state == S_ABORT || cur_state == S_AB_UNL1));

    // R9
    abort_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == S_AB_UNL2 && !(bus_we && bus_wdata[7:0] == CMD_RESET)) |=> cur_state != S_READ);

    // R10
    prog_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == S_PROG && bus_re) |-> (!bus_rdata[5] && !bus_rdata[1]));

    // R11
    fault_dq5_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == S_FAULT && bus_re) |-> bus_rdata[5]);

    // R11
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == S_FAULT && !(bus_we && bus_wdata[7:0] == CMD_RESET)) |=> cur_state == S_FAULT);

    // R2
    commit_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> cur_state == S_READ);
endmodule

bind wbuf_prog_seq wbp_checker #(.AW(AW), .DW(DW), .PAGE_AW(PAGE_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cur_state (cur_state),
    .page      (q.page),
    .page_set  (q.page_set),
    .commit    (commit)
);

// File: tb/wbuf_prog_seq_bench.sv
module wbuf_prog_seq_bench;
    localparam int AW    = 11;
    localparam int DW    = 16;
    localparam int PROG  = 24;
    localparam int LIMIT = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          timeout_in = 1'b0;
    logic [DW-1:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    wbuf_prog_seq #(.AW(AW), .DW(DW), .PAGE_AW(4), .SECT_AW(8), .PROG_CYCLES(PROG)) u_wbuf_prog_seq (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .timeout_in(timeout_in), .bus_rdata(bus_rdata)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > LIMIT) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] dat);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = dat;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] dat);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        #2 dat = bus_rdata;
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    task automatic start_buf(input logic [AW-1:0] sa, input logic [DW-1:0] cnt);
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
        wr(sa, 16'h0025);
        wr(sa, cnt);
    endtask

    task automatic abort_reset();
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
        wr(11'h000, 16'h00F0);
    endtask

    task automatic wait_prog();
        repeat (PROG + 6) @(posedge clk);
    endtask

    // Status read with toggle check: bit6 masked, then second read must flip bit6.
    task automatic chk_status(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        logic [DW-1:0] s1, s2;
        rd(a, s1);
        rd(a, s2);
        chk(req, s1 & 16'hFFBF, exp);
        chk({req, " toggle"}, {15'd0, s1[6] ^ s2[6]}, 16'd1);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rd(11'h000, v); chk("R1 reset 000", v, 16'hFFFF);
        rd(11'h7FF, v); chk("R1 reset 7FF", v, 16'hFFFF);
    endtask

    task automatic t_program();
        logic [DW-1:0] v;
        start_buf(11'h200, 16'd3);
        wr(11'h210, 16'h1234);
        wr(11'h211, 16'hABCD);
        wr(11'h215, 16'h00F0);
        wr(11'h21F, 16'h8001);
        wr(11'h200, 16'h0029);
        chk_status("R10 busy status", 11'h21F, 16'h0080);
        wr(11'h213, 16'h0000);
        wait_prog();
        rd(11'h210, v); chk("R2 word 210", v, 16'h1234);
        rd(11'h211, v); chk("R2 word 211", v, 16'hABCD);
        rd(11'h215, v); chk("R2 word 215", v, 16'h00F0);
        rd(11'h21F, v); chk("R2 word 21F", v, 16'h8001);
        rd(11'h212, v); chk("R2 unloaded 212", v, 16'hFFFF);
        rd(11'h213, v); chk("R10 write during prog ignored", v, 16'hFFFF);
    endtask

    task automatic t_and_last();
        logic [DW-1:0] v;
        start_buf(11'h2F3, 16'd3);
        wr(11'h210, 16'hFF00);
        wr(11'h211, 16'hFFFF);
        wr(11'h212, 16'h5555);
        wr(11'h212, 16'h0F0F);
        wr(11'h2AB, 16'h0029);
        wait_prog();
        rd(11'h210, v); chk("R2 AND merge", v, 16'h1200);
        rd(11'h211, v); chk("R2 ones keep zeros", v, 16'hABCD);
        rd(11'h212, v); chk("R3 last load wins", v, 16'h0F0F);
    endtask

    task automatic t_count_abort();
        logic [DW-1:0] v;
        start_buf(11'h200, 16'd16);
        chk_status("R4 R8 count abort", 11'h200, 16'h0082);
        wr(11'h000, 16'h00F0);
        rd(11'h210, v); chk("R9 lone F0 keeps abort", v & 16'hFFBF, 16'h0082);
        abort_reset();
        rd(11'h210, v); chk("R9 reset seq to read", v, 16'h1200);
    endtask

    task automatic t_sector_abort();
        logic [DW-1:0] v;
        start_buf(11'h200, 16'd1);
        wr(11'h310, 16'h0000);
        chk_status("R5 sector abort", 11'h310, 16'h0082);
        abort_reset();
        rd(11'h310, v); chk("R5 R8 array untouched", v, 16'hFFFF);
    endtask

    task automatic t_page_abort();
        logic [DW-1:0] v;
        start_buf(11'h200, 16'd3);
        wr(11'h230, 16'h0080);
        wr(11'h241, 16'h0000);
        chk_status("R6 R8 page abort dq7", 11'h230, 16'h0002);
        abort_reset();
        rd(11'h230, v); chk("R8 no program on abort", v, 16'hFFFF);
    endtask

    task automatic t_confirm_abort();
        logic [DW-1:0] v;
        start_buf(11'h200, 16'd0);
        wr(11'h250, 16'h0000);
        wr(11'h200, 16'h0030);
        chk_status("R7 wrong confirm data", 11'h250, 16'h0082);
        abort_reset();
        rd(11'h250, v); chk("R7 array untouched", v, 16'hFFFF);
        start_buf(11'h200, 16'd0);
        wr(11'h251, 16'h0000);
        wr(11'h300, 16'h0029);
        rd(11'h251, v); chk("R7 confirm wrong sector", v & 16'hFFBF, 16'h0082);
        // R9: a fresh buffer-load attempt while aborted changes nothing
        start_buf(11'h200, 16'd0);
        rd(11'h251, v); chk("R9 new command ignored", v & 16'hFFBF, 16'h0082);
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
        wr(11'h000, 16'h00F1);
        rd(11'h251, v); chk("R9 broken reset seq", v & 16'hFFBF, 16'h0082);
        abort_reset();
        rd(11'h251, v); chk("R9 read mode after reset", v, 16'hFFFF);
    endtask

    task automatic t_timeout();
        logic [DW-1:0] v;
        start_buf(11'h200, 16'd0);
        wr(11'h260, 16'h0000);
        wr(11'h200, 16'h0029);
        @(negedge clk); timeout_in = 1'b1;
        @(posedge clk); #1 timeout_in = 1'b0;
        rd(11'h260, v); chk("R11 dq5 set", v & 16'hFFBF, 16'h00A0);
        wait_prog();
        rd(11'h260, v); chk("R11 fault held", v & 16'hFFBF, 16'h00A0);
        wr(11'h000, 16'h00F0);
        rd(11'h260, v); chk("R11 no program after timeout", v, 16'hFFFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_program();
        t_and_last();
        t_count_abort();
        t_sector_abort();
        t_page_abort();
        t_confirm_abort();
        t_timeout();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule